// File: doc/BRIEF.md
# Link transport test pattern generator

This block stands in for the converter samples at the sample interface of a serial converter link transmitter. Each clock cycle it presents one whole frame: a bus of sample slots for up to `MAX_M` converters with up to `MAX_S` samples each. Every sample is 16 bits wide and carries no control bits. The number of converters, samples per converter and frames per multiframe in use come from configuration inputs. Slots beyond the configured counts are driven to zero.

A mode input chooses what the frame holds:
- **Short pattern:** every octet position of the frame carries its own programmed value. The frame repeats on every cycle.
- **PRBS:** the active samples are filled from a PRBS-15 stream.
- **Latency:** the frame stays at zero. After a one-shot request, a single negative full-scale sample (0x8000) is launched on the next multiframe boundary. The sample's MSB is copied to a strobe pin so an instrument can time the link end to end.

Lane mapping and link framing happen downstream of this block.

Top module: `link_tpat_gen`

## Requirements
- R1: While reset (`rst_ni` low, synchronous) is applied and in the first cycle after it, `smp_o` is all zero, `smp_valid_o` is 0 and `lat_strobe_o` is 0. The PRBS state is reloaded with 15'h7FFF.
- R2: Outputs are registered, so inputs sampled at one edge appear after that edge. `smp_valid_o` equals `en_i` from the previous edge. With `en_i` low, `smp_o` is zero and the PRBS state holds.
- R3: `mode_i` is encoded as 0 = short pattern, 1 = PRBS, 2 = latency and 3 = idle. In short-pattern mode, active sample (converter c, sample s) has frame index i = c*cfg_s + s. Octet n of the pattern is `pat_i[8n+7:8n]`. The sample word is {octet 2i, octet 2i+1}, with the first octet in the upper byte.
- R4: Each sample slot (c, s) sits at `smp_o[16*(c*MAX_S+s) +: 16]`. In short-pattern mode, the frame repeats unchanged on every cycle while the pattern is held.
- R5: A slot with c >= cfg_m or s >= cfg_s is zero in every mode.
- R6: PRBS mode runs the x^15 + x^14 + 1 generator. Each step computes fb = s[14] ^ s[13] and shifts s left, taking fb in at bit 0. Each active sample takes 16 successive fb bits, MSB first, with samples filled in frame-index order. The state advances by one sample per active sample per cycle, and holds in any other mode.
- R7: In latency mode and idle mode, every sample is zero except the launched pulse. The pulse word is 16'h8000 in slot 0.
- R8: A request on `lat_req_i` is captured at one edge. The multiframe counter resets to 0 and counts 0 to cfg_k-1, advancing once per cycle. The pulse launches at the first later edge where the counter is 0, with latency mode and enable set.
- R9: `lat_strobe_o` is high exactly in the cycle that carries the pulse, equal to the pulse word's MSB.
- R10: Each request launches exactly one pulse. A request made while one is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Generate enable |
| mode_i | input | 2 | Pattern select (0 short, 1 PRBS, 2 latency, 3 idle) |
| cfg_m_i | input | $clog2(MAX_M+1) | Converters in use |
| cfg_s_i | input | $clog2(MAX_S+1) | Samples per converter per frame |
| cfg_k_i | input | $clog2(MAX_K+1) | Frames per multiframe |
| pat_i | input | 16*MAX_M*MAX_S | Programmed octet values, octet n at [8n+7:8n] |
| lat_req_i | input | 1 | One-shot latency pulse request |
| smp_o | output | 16*MAX_M*MAX_S | Frame of sample slots |
| smp_valid_o | output | 1 | Frame valid |
| lat_strobe_o | output | 1 | MSB of the latency pulse sample |

## Verification
The bench builds the block with its defaults: MAX_M = 2, MAX_S = 2 and MAX_K = 32. Four slots are enough to cover the cases where only a row of slots, only a column, or only slot 0 is active, so the frame-index and slot-position mappings are tested separately. The same defaults allow multiframe lengths of 1, 3 and 4. This covers a request captured exactly on a boundary, a request followed by a back-to-back launch, and a duplicate request while one is pending.

// File: rtl/link_tpat_pkg.sv
package link_tpat_pkg;

    localparam int SMP_W = 16;
    localparam int OCT_W = 8;

    typedef enum logic [1:0] {
        MODE_SHORT = 2'd0,
        MODE_PRBS  = 2'd1,
        MODE_PULSE = 2'd2,
        MODE_IDLE  = 2'd3
    } tp_mode_e;

    localparam logic [14:0]      PRBS_SEED  = 15'h7FFF;
    localparam logic [SMP_W-1:0] PULSE_WORD = 16'h8000;

    typedef struct packed {
        logic [14:0]      state;
        logic [SMP_W-1:0] word;
    } prbs_step_t;

    // Produce one 16-bit sample from x^15 + x^14 + 1, MSB first
    function automatic prbs_step_t prbs_advance(input logic [14:0] cur);
        prbs_step_t r;
        logic [14:0] s;
        logic fb;
        s      = cur;
        r.word = '0;
        for (int b = SMP_W - 1; b >= 0; b--) begin
            fb        = s[14] ^ s[13];
            r.word[b] = fb;
            s         = {s[13:0], fb};
        end
        r.state = s;
        return r;
    endfunction

endpackage

// File: rtl/link_tpat_prbs.sv
module link_tpat_prbs #(
    parameter int NSLOT = 4,
    localparam int CW   = $clog2(NSLOT + 1)
) (
    input  logic [14:0]        state_i,
    input  logic [CW-1:0]      adv_i,
    output logic [NSLOT*16-1:0] words_o,
    output logic [14:0]        next_o
);
    import link_tpat_pkg::*;

    logic [14:0] chain [NSLOT+1];
    assign chain[0] = state_i;

    for (genvar g = 0; g < NSLOT; g++) begin : g_step
        prbs_step_t stp;
        assign stp           = prbs_advance(chain[g]);
        assign chain[g+1]    = stp.state;
        assign words_o[g*16 +: 16] = stp.word;
    end

    always_comb begin
        next_o = chain[0];
        for (int i = 0; i <= NSLOT; i++) begin
            if (adv_i == CW'(i)) next_o = chain[i];
        end
    end
endmodule

// File: rtl/link_tpat_mframe.sv
module link_tpat_mframe #(
    parameter int MAX_K = 32,
    localparam int KW   = $clog2(MAX_K + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [KW-1:0] cfg_k_i,
    output logic          boundary_o
);
    typedef struct packed {
        logic [KW-1:0] cnt;
    } mf_state_t;

    mf_state_t mf_d, mf_q;
    logic [KW:0] inc;

    always_comb begin
        mf_d = mf_q;
        inc  = {1'b0, mf_q.cnt} + {{KW{1'b0}}, 1'b1};
        if (inc >= {1'b0, cfg_k_i}) mf_d.cnt = '0;
        else                        mf_d.cnt = inc[KW-1:0];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) mf_q <= '0;
        else         mf_q <= mf_d;
    end

    assign boundary_o = (mf_q.cnt == '0);

    // R8: counter either restarts at zero or steps by one
    p_mf_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mf_q.cnt != '0) |-> (mf_q.cnt == $past(mf_q.cnt) + KW'(1)));
endmodule

// File: rtl/link_tpat_gen.sv
module link_tpat_gen #(
    parameter int MAX_M = 2,
    parameter int MAX_S = 2,
    parameter int MAX_K = 32,
    localparam int NSLOT = MAX_M * MAX_S,
    localparam int BUS_W = NSLOT * 16,
    localparam int MW    = $clog2(MAX_M + 1),
    localparam int SW    = $clog2(MAX_S + 1),
    localparam int KW    = $clog2(MAX_K + 1),
    localparam int CW    = $clog2(NSLOT + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [1:0]       mode_i,
    input  logic [MW-1:0]    cfg_m_i,
    input  logic [SW-1:0]    cfg_s_i,
    input  logic [KW-1:0]    cfg_k_i,
    input  logic [BUS_W-1:0] pat_i,
    input  logic             lat_req_i,
    output logic [BUS_W-1:0] smp_o,
    output logic             smp_valid_o,
    output logic             lat_strobe_o
);
    import link_tpat_pkg::*;

    typedef struct packed {
        logic [BUS_W-1:0] smp;
        logic             valid;
        logic             strobe;
        logic             pend;
        logic [14:0]      prbs;
    } gen_state_t;

    gen_state_t st_d, st_q;

    logic             mf_boundary;
    logic [BUS_W-1:0] prbs_words;
    logic [14:0]      prbs_next;
    logic [CW-1:0]    adv;
    logic             launch;
    int               act_m, act_s, idx;

    link_tpat_mframe #(.MAX_K(MAX_K)) u_mframe (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cfg_k_i    (cfg_k_i),
        .boundary_o (mf_boundary)
    );

    link_tpat_prbs #(.NSLOT(NSLOT)) u_prbs (
        .state_i (st_q.prbs),
        .adv_i   (adv),
        .words_o (prbs_words),
        .next_o  (prbs_next)
    );

    always_comb begin
        act_m = (int'(cfg_m_i) > MAX_M) ? MAX_M : int'(cfg_m_i);
        act_s = (int'(cfg_s_i) > MAX_S) ? MAX_S : int'(cfg_s_i);
        adv   = CW'(act_m * act_s);
    end

    always_comb begin
        st_d        = st_q;
        st_d.valid  = en_i;
        st_d.strobe = 1'b0;
        st_d.smp    = '0;
        idx         = 0;
        launch      = st_q.pend && mf_boundary && en_i &&
                      (tp_mode_e'(mode_i) == MODE_PULSE);
        st_d.pend   = launch ? 1'b0 : (st_q.pend | lat_req_i);
        if (en_i) begin
            case (tp_mode_e'(mode_i))
                MODE_SHORT: begin
                    for (int c = 0; c < MAX_M; c++) begin
                        for (int s = 0; s < MAX_S; s++) begin
                            if (c < act_m && s < act_s) begin
                                idx = c * act_s + s;
                                st_d.smp[(c*MAX_S+s)*16 +: 16] =
                                    {pat_i[(2*idx)*8 +: 8], pat_i[(2*idx+1)*8 +: 8]};
                            end
                        end
                    end
                end
                MODE_PRBS: begin
                    for (int c = 0; c < MAX_M; c++) begin
                        for (int s = 0; s < MAX_S; s++) begin
                            if (c < act_m && s < act_s) begin
                                idx = c * act_s + s;
                                st_d.smp[(c*MAX_S+s)*16 +: 16] = prbs_words[idx*16 +: 16];
                            end
                        end
                    end
                    st_d.prbs = prbs_next;
                end
                MODE_PULSE: begin
                    if (launch) begin
                        st_d.smp[15:0] = PULSE_WORD;
                        st_d.strobe    = PULSE_WORD[15];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.prbs <= PRBS_SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assign smp_o        = st_q.smp;
    assign smp_valid_o  = st_q.valid;
    assign lat_strobe_o = st_q.strobe;

    // R2: valid follows enable by one cycle; disabled frames are empty
    p_valid_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i |=> smp_valid_o);
    p_idle_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (smp_o == '0));
    // R6: generator never locks up in the all-zero state
    p_prbs_nonzero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.prbs != '0);
    // R8: pulse only follows a multiframe boundary in latency mode
    p_strobe_boundary_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lat_strobe_o |-> ($past(mf_boundary) && $past(mode_i) == MODE_PULSE));
    // R9: strobe accompanies the full-scale negative word
    p_strobe_word_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lat_strobe_o |-> (smp_o[15:0] == PULSE_WORD));

    // R5: slots outside the configured grid stay empty
    for (genvar c = 0; c < MAX_M; c++) begin : g_chk_m
        for (genvar s = 0; s < MAX_S; s++) begin : g_chk_s
            p_inactive_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (int'($past(cfg_m_i)) <= c || int'($past(cfg_s_i)) <= s) |->
                (smp_o[(c*MAX_S+s)*16 +: 16] == 16'h0000));
        end
    end
endmodule

// File: tb/sim_link_tpat_gen.sv
module sim_link_tpat_gen;
    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        en_i = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic [1:0]  cfg_m_i = 2'd2;
    logic [1:0]  cfg_s_i = 2'd2;
    logic [5:0]  cfg_k_i = 6'd4;
    logic [63:0] pat_i = '0;
    logic        lat_req_i = 1'b0;
    logic [63:0] smp_o;
    logic        smp_valid_o;
    logic        lat_strobe_o;

    int checks = 0;
    int failures = 0;
    int edge_n = 0;
    logic [14:0] ms;

    always #10 clk = ~clk;

    link_tpat_gen u0 (
        .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .mode_i(mode_i),
        .cfg_m_i(cfg_m_i), .cfg_s_i(cfg_s_i), .cfg_k_i(cfg_k_i),
        .pat_i(pat_i), .lat_req_i(lat_req_i),
        .smp_o(smp_o), .smp_valid_o(smp_valid_o), .lat_strobe_o(lat_strobe_o)
    );

    // Short-pattern vectors: pattern, converters, samples, expected frame (R3, R4)
    localparam logic [63:0] TV_PAT [5] = '{64'h8877665544332211, 64'h8877665544332211,
        64'h8877665544332211, 64'h8877665544332211, 64'hF0E1D2C3B4A59687};
    localparam logic [1:0]  TV_M [5] = '{2'd2, 2'd1, 2'd2, 2'd1, 2'd2};
    localparam logic [1:0]  TV_S [5] = '{2'd2, 2'd2, 2'd1, 2'd1, 2'd2};
    localparam logic [63:0] TV_EXP [5] = '{64'h7788_5566_3344_1122, 64'h0000_0000_3344_1122,
        64'h0000_3344_0000_1122, 64'h0000_0000_0000_1122, 64'hE1F0_C3D2_A5B4_8796};

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        edge_n++;
    endtask

    task automatic do_reset();
        rst_ni = 1'b0;
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        edge_n = 0;
        ms = 15'h7FFF;
    endtask

    function automatic logic [15:0] model_word(inout logic [14:0] s);
        logic [15:0] w;
        logic fb;
        for (int b = 15; b >= 0; b--) begin
            fb = s[14] ^ s[13];
            w[b] = fb;
            s = {s[13:0], fb};
        end
        return w;
    endfunction

    // R7 R8 R9 R10: one request, optional duplicate while pending
    task automatic lat_trial(input int k, input int waits, input bit dup);
        int r, l;
        do_reset();
        cfg_k_i = 6'(k); cfg_m_i = 2'd2; cfg_s_i = 2'd2;
        mode_i = 2'd2; en_i = 1'b1;
        repeat (waits) step();
        lat_req_i = 1'b1;
        step();
        r = edge_n;
        lat_req_i = 1'b0;
        l = r + 1;
        while (((l - 1) % k) != 0) l++;
        chk("R8 no pulse at request edge", smp_o, 64'h0);
        for (int i = 0; i < 2 * k + 3; i++) begin
            if (dup && i == 0 && l > r + 1) lat_req_i = 1'b1;
            step();
            lat_req_i = 1'b0;
            chk("R7 R8 R10 pulse frame", smp_o, (edge_n == l) ? 64'h8000 : 64'h0);
            chk("R9 strobe", {63'b0, lat_strobe_o}, {63'b0, (edge_n == l)});
        end
    endtask

    initial begin
        // R1: reset state
        rst_ni = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset samples", smp_o, 64'h0);
        chk("R1 reset valid/strobe", {62'b0, smp_valid_o, lat_strobe_o}, 64'h0);
        do_reset();
        chk("R1 samples after release", smp_o, 64'h0);

        // R3 R4: vector table
        en_i = 1'b1; mode_i = 2'd0;
        for (int v = 0; v < 5; v++) begin
            pat_i = TV_PAT[v]; cfg_m_i = TV_M[v]; cfg_s_i = TV_S[v];
            step();
            chk("R3 R5 short frame", smp_o, TV_EXP[v]);
            step();
            chk("R4 short repeat", smp_o, TV_EXP[v]);
        end
        chk("R2 valid high", {63'b0, smp_valid_o}, 64'h1);

        // R6: PRBS from seed, 4 samples per frame
        do_reset();
        en_i = 1'b1; mode_i = 2'd1; cfg_m_i = 2'd2; cfg_s_i = 2'd2;
        for (int i = 0; i < 4; i++) begin
            logic [15:0] w0, w1, w2, w3;
            step();
            w0 = model_word(ms); w1 = model_word(ms); w2 = model_word(ms); w3 = model_word(ms);
            chk("R6 prbs 2x2", smp_o, {w3, w2, w1, w0});
        end
        // R6: hold in another mode, resume
        mode_i = 2'd0; step(); step();
        mode_i = 2'd1; cfg_m_i = 2'd2; cfg_s_i = 2'd1;
        for (int i = 0; i < 3; i++) begin
            logic [15:0] w0, w1;
            step();
            w0 = model_word(ms); w1 = model_word(ms);
            chk("R6 R5 prbs 2x1", smp_o, {16'h0, w1, 16'h0, w0});
        end
        // R2: enable low empties the frame and holds the PRBS
        en_i = 1'b0;
        step();
        chk("R2 disabled frame", smp_o, 64'h0);
        chk("R2 valid low", {63'b0, smp_valid_o}, 64'h0);
        step();
        en_i = 1'b1; cfg_m_i = 2'd1; cfg_s_i = 2'd1;
        for (int i = 0; i < 3; i++) begin
            logic [15:0] w0;
            step();
            w0 = model_word(ms);
            chk("R6 R2 prbs 1x1 after hold", smp_o, {48'h0, w0});
        end
        // R7: idle mode 3 is empty but valid
        mode_i = 2'd3;
        step();
        chk("R7 idle mode zero", smp_o, 64'h0);
        chk("R2 idle valid", {63'b0, smp_valid_o}, 64'h1);

        // R7 R8 R9 R10 latency trials
        lat_trial(4, 2, 1'b0);
        lat_trial(4, 4, 1'b0);
        lat_trial(1, 0, 1'b0);
        lat_trial(3, 1, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule